// File: doc/BRIEF.md
# ADC Calibration Sequencer

This block orders the calibration steps of a successive-approximation converter. A request comes either from the calibration pin or from a one-cycle software start strobe. The block then raises a busy flag and walks through up to three timed phases: internal DAC trim, system gain and system offset. Each phase opens with a single-cycle start strobe to its engine. The engines are outside this block. Each phase is modelled as a wait of a parameterised number of master clocks.

A two-bit type input picks one of four flows. In the full flow the DAC and gain phases run back to back. Busy then drops, and the block waits for a rising edge on the conversion-start pin before it runs the offset phase. The gain-plus-offset flow is the same but has no DAC phase. The two single flows run only a gain phase or only an offset phase and never look at the conversion-start pin.

A falling edge on the calibration pin is an internal reset: it aborts any flow and pulses a reset strobe. The next rising edge on that pin starts a new flow. The polarity selection (bipolar or unipolar) is captured at each start. It tells the offset engine to null either the midscale or the zero-scale error. Gain always targets positive full scale. Both pins are asynchronous and pass through a configurable synchronizer.

Top module: `cal_seq_ctrl`

## Requirements
- R1: While rst_ni is low and right after it is released, busy_o, all three start strobes, cal_reset_o and ofs_midscale_o are 0.
- R2: A falling edge on cal_pin_i gives a one-cycle cal_reset_o pulse, SYNC_STAGES clock edges after the edge that first samples the low level. In that same cycle busy_o is 0 and any running flow is abandoned.
- R3: A rising edge on cal_pin_i starts a flow, with busy_o and the first phase strobe high SYNC_STAGES edges after the sampling edge. sw_start_i starts a flow on the edge that samples it.
- R4: With cal_type_i = 2'b00 (full), dac_cal_start_o pulses as busy_o rises and gain_cal_start_o pulses DAC_CYCLES cycles later. busy_o stays high for DAC_CYCLES + GAIN_CYCLES cycles and then stays low while an offset phase is pending.
- R5: While an offset phase is pending, a rising edge on convst_pin_i raises busy_o with an ofs_cal_start_o pulse SYNC_STAGES edges after the sampling edge. busy_o then stays high for OFS_CYCLES cycles and the flow ends.
- R6: With cal_type_i = 2'b01 (gain plus offset), no DAC strobe is issued. gain_cal_start_o pulses as busy_o rises, busy_o lasts GAIN_CYCLES cycles, and an offset phase is left pending.
- R7: With cal_type_i = 2'b10 (gain only), busy_o lasts GAIN_CYCLES cycles with one gain strobe. No offset phase is left pending.
- R8: With cal_type_i = 2'b11 (offset only), busy_o lasts OFS_CYCLES cycles with one offset strobe and no other strobe.
- R9: A convst_pin_i rising edge while busy_o is high, or while no offset phase is pending, produces no strobe and does not raise busy_o.
- R10: Start requests (pin or software) while busy_o is high are ignored and do not lengthen the running phase.
- R11: ofs_midscale_o equals bipolar_i as sampled at the start of the flow and holds that value throughout the flow.
- R12: Every start strobe and cal_reset_o is one cycle wide, and at most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cal_pin_i | input | 1 | Calibration pin, idles high; fall resets, rise starts |
| convst_pin_i | input | 1 | Conversion-start pin; rise launches pending offset phase |
| sw_start_i | input | 1 | Synchronous one-cycle software start |
| cal_type_i | input | 2 | Flow select: 00 full, 01 gain+offset, 10 gain, 11 offset |
| bipolar_i | input | 1 | Input range polarity captured at start |
| busy_o | output | 1 | High while a calibration phase runs |
| dac_cal_start_o | output | 1 | Start strobe to the DAC trim engine |
| gain_cal_start_o | output | 1 | Start strobe to the gain engine |
| ofs_cal_start_o | output | 1 | Start strobe to the offset engine |
| cal_reset_o | output | 1 | Internal reset strobe on calibration pin fall |
| ofs_midscale_o | output | 1 | Offset target: 1 midscale, 0 zero scale |

## Verification
A wrong sequencer state shows at once in the busy length. A phase counted one cycle short or long shifts the busy fall by one cycle, and the bench measures that fall exactly. A flow that loses its pending offset, or one that leaves an offset pending when it should not, shows on the first conversion-start edge. The block either fails to raise busy or raises it when it should stay silent, SYNC_STAGES edges after the pin changes. A stale polarity or mode capture shows as a wrong strobe or target bit in the first cycle of the next phase.

// File: rtl/cal_seq_pkg.sv
`timescale 1ns/1ps
package cal_seq_pkg;

  typedef enum logic [1:0] {
    MODE_FULL     = 2'b00,
    MODE_GAIN_OFS = 2'b01,
    MODE_GAIN     = 2'b10,
    MODE_OFS      = 2'b11
  } cal_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DAC,
    ST_GAIN,
    ST_WAIT,
    ST_OFS
  } cal_state_e;

  typedef struct packed {
    logic dac;
    logic gain;
    logic ofs;
  } cal_strobe_t;

endpackage

// File: rtl/cal_pin_sync.sv
`timescale 1ns/1ps
module cal_pin_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= RST_VAL;
        else         sync_q <= pin_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= {STAGES{RST_VAL}};
        else         sync_q <= {sync_q[STAGES-2:0], pin_i};
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= sync_q[STAGES-1];
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
  assign fall_o = ~sync_q[STAGES-1] & prev_q;

endmodule

// File: rtl/cal_phase_timer.sv
`timescale 1ns/1ps
module cal_phase_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/cal_seq_fsm.sv
`timescale 1ns/1ps
module cal_seq_fsm
  import cal_seq_pkg::*;
#(
  parameter int unsigned DAC_CYCLES  = 4,
  parameter int unsigned GAIN_CYCLES = 4,
  parameter int unsigned OFS_CYCLES  = 4,
  parameter int unsigned CNT_W       = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  cal_mode_e        mode_i,
  input  logic             bipolar_i,
  input  logic             convst_rise_i,
  input  logic             abort_i,
  input  logic             tmr_done_i,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_val_o,
  output logic             busy_o,
  output cal_strobe_t      stb_o,
  output logic             rst_pulse_o,
  output logic             midscale_o
);

  localparam logic [CNT_W-1:0] DAC_LD  = CNT_W'(DAC_CYCLES - 1);
  localparam logic [CNT_W-1:0] GAIN_LD = CNT_W'(GAIN_CYCLES - 1);
  localparam logic [CNT_W-1:0] OFS_LD  = CNT_W'(OFS_CYCLES - 1);

  cal_state_e  st_q, st_n;
  cal_mode_e   mode_q;
  cal_strobe_t stb_q, stb_n;
  logic        rst_q;
  logic        midscale_q;
  logic        accept;

  assign accept = !abort_i && start_i && (st_q == ST_IDLE || st_q == ST_WAIT);

  always_comb begin
    st_n       = st_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    stb_n      = '0;
    if (abort_i) begin
      st_n = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE, ST_WAIT: begin
          if (start_i) begin
            tmr_load_o = 1'b1;
            unique case (mode_i)
              MODE_FULL: begin
                st_n = ST_DAC;  tmr_val_o = DAC_LD;  stb_n.dac = 1'b1;
              end
              MODE_GAIN_OFS, MODE_GAIN: begin
                st_n = ST_GAIN; tmr_val_o = GAIN_LD; stb_n.gain = 1'b1;
              end
              default: begin
                st_n = ST_OFS;  tmr_val_o = OFS_LD;  stb_n.ofs = 1'b1;
              end
            endcase
          end else if (st_q == ST_WAIT && convst_rise_i) begin
            st_n = ST_OFS; tmr_load_o = 1'b1; tmr_val_o = OFS_LD; stb_n.ofs = 1'b1;
          end
        end
        ST_DAC: begin
          if (tmr_done_i) begin
            st_n = ST_GAIN; tmr_load_o = 1'b1; tmr_val_o = GAIN_LD; stb_n.gain = 1'b1;
          end
        end
        ST_GAIN: begin
          if (tmr_done_i) st_n = (mode_q == MODE_GAIN) ? ST_IDLE : ST_WAIT;
        end
        ST_OFS: begin
          if (tmr_done_i) st_n = ST_IDLE;
        end
        default: st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      mode_q     <= MODE_FULL;
      stb_q      <= '0;
      rst_q      <= 1'b0;
      midscale_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      stb_q <= stb_n;
      rst_q <= abort_i;
      if (accept) begin
        mode_q     <= mode_i;
        midscale_q <= bipolar_i;
      end
    end
  end

  assign busy_o      = (st_q == ST_DAC) || (st_q == ST_GAIN) || (st_q == ST_OFS);
  assign stb_o       = stb_q;
  assign rst_pulse_o = rst_q;
  assign midscale_o  = midscale_q;

endmodule

// File: rtl/cal_seq_ctrl.sv
`timescale 1ns/1ps
module cal_seq_ctrl
  import cal_seq_pkg::*;
#(
  parameter int unsigned DAC_CYCLES  = 97215,
  parameter int unsigned GAIN_CYCLES = 13899,
  parameter int unsigned OFS_CYCLES  = 13899,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cal_pin_i,
  input  logic       convst_pin_i,
  input  logic       sw_start_i,
  input  logic [1:0] cal_type_i,
  input  logic       bipolar_i,
  output logic       busy_o,
  output logic       dac_cal_start_o,
  output logic       gain_cal_start_o,
  output logic       ofs_cal_start_o,
  output logic       cal_reset_o,
  output logic       ofs_midscale_o
);

  localparam int unsigned MAX_A   = (DAC_CYCLES > GAIN_CYCLES) ? DAC_CYCLES : GAIN_CYCLES;
  localparam int unsigned MAX_CYC = (MAX_A > OFS_CYCLES) ? MAX_A : OFS_CYCLES;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  logic             cal_rise, cal_fall;
  logic             cv_rise, cv_fall_unused;
  logic             tmr_load, tmr_done;
  logic [CNT_W-1:0] tmr_val;
  cal_strobe_t      stb;

  cal_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cal_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (cal_pin_i),
    .rise_o (cal_rise),
    .fall_o (cal_fall)
  );

  cal_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_cv_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (convst_pin_i),
    .rise_o (cv_rise),
    .fall_o (cv_fall_unused)
  );

  cal_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .done_o     (tmr_done)
  );

  cal_seq_fsm #(
    .DAC_CYCLES  (DAC_CYCLES),
    .GAIN_CYCLES (GAIN_CYCLES),
    .OFS_CYCLES  (OFS_CYCLES),
    .CNT_W       (CNT_W)
  ) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (cal_rise | sw_start_i),
    .mode_i        (cal_mode_e'(cal_type_i)),
    .bipolar_i     (bipolar_i),
    .convst_rise_i (cv_rise),
    .abort_i       (cal_fall),
    .tmr_done_i    (tmr_done),
    .tmr_load_o    (tmr_load),
    .tmr_val_o     (tmr_val),
    .busy_o        (busy_o),
    .stb_o         (stb),
    .rst_pulse_o   (cal_reset_o),
    .midscale_o    (ofs_midscale_o)
  );

  assign dac_cal_start_o  = stb.dac;
  assign gain_cal_start_o = stb.gain;
  assign ofs_cal_start_o  = stb.ofs;

endmodule

// File: rtl/cal_seq_ctrl_chk.sv
`timescale 1ns/1ps
module cal_seq_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic busy_o,
  input logic dac_cal_start_o,
  input logic gain_cal_start_o,
  input logic ofs_cal_start_o,
  input logic cal_reset_o,
  input logic ofs_midscale_o
);

  assert_one_hot_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({dac_cal_start_o, gain_cal_start_o, ofs_cal_start_o, cal_reset_o}));

  assert_strobe_width_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dac_cal_start_o || gain_cal_start_o || ofs_cal_start_o || cal_reset_o) |=>
    !(dac_cal_start_o || gain_cal_start_o || ofs_cal_start_o || cal_reset_o));

  assert_reset_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_reset_o |-> !busy_o);

  assert_dac_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dac_cal_start_o |-> busy_o);

  assert_ofs_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ofs_cal_start_o |-> busy_o);

  assert_busy_needs_strobe_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (dac_cal_start_o || gain_cal_start_o || ofs_cal_start_o));

  assert_target_held_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(ofs_midscale_o));

endmodule

bind cal_seq_ctrl cal_seq_ctrl_chk u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .busy_o           (busy_o),
  .dac_cal_start_o  (dac_cal_start_o),
  .gain_cal_start_o (gain_cal_start_o),
  .ofs_cal_start_o  (ofs_cal_start_o),
  .cal_reset_o      (cal_reset_o),
  .ofs_midscale_o   (ofs_midscale_o)
);

// File: tb/cal_seq_ctrl_tb.sv
`timescale 1ns/1ps
module cal_seq_ctrl_tb;

  localparam int DAC  = 20;
  localparam int GAIN = 12;
  localparam int OFS  = 9;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cal_pin = 1'b1;
  logic convst = 1'b0;
  logic sw_start = 1'b0;
  logic [1:0] cal_type = 2'b00;
  logic bipolar = 1'b0;
  logic busy, dac_s, gain_s, ofs_s, cal_rst, midscale;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  cal_seq_ctrl #(
    .DAC_CYCLES(DAC), .GAIN_CYCLES(GAIN), .OFS_CYCLES(OFS), .SYNC_STAGES(SYNC)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cal_pin_i(cal_pin), .convst_pin_i(convst),
    .sw_start_i(sw_start), .cal_type_i(cal_type), .bipolar_i(bipolar),
    .busy_o(busy), .dac_cal_start_o(dac_s), .gain_cal_start_o(gain_s),
    .ofs_cal_start_o(ofs_s), .cal_reset_o(cal_rst), .ofs_midscale_o(midscale)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // Called just after the entry edge; measures busy length and strobes.
  task automatic track(output int len, output int gidx, output int nd,
                       output int ng, output int no, output int ovl);
    len = 0; gidx = -1; nd = 0; ng = 0; no = 0; ovl = 0;
    while (busy && len < 1000) begin
      if (dac_s) nd++;
      if (gain_s) begin ng++; if (gidx < 0) gidx = len; end
      if (ofs_s) no++;
      if ((int'(dac_s) + int'(gain_s) + int'(ofs_s) + int'(cal_rst)) > 1) ovl++;
      len++;
      @(posedge clk); #1;
    end
  endtask

  task automatic sw_go(logic [1:0] mode, logic bip);
    @(negedge clk);
    cal_type = mode; bipolar = bip; sw_start = 1'b1;
    @(posedge clk); #1;
    sw_start = 1'b0;
  endtask

  task automatic convst_go();
    @(negedge clk); convst = 1'b1;
    @(posedge clk);
    repeat (SYNC - 1) @(posedge clk);
    #1;
    chk("R5", "busy one edge before convst acts", int'(busy), 0);
    @(posedge clk); #1;
  endtask

  task automatic idle_watch(string req, int cycles);
    int seen = 0;
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk); #1;
      if (busy || dac_s || gain_s || ofs_s) seen++;
    end
    chk(req, "activity while idle", seen, 0);
  endtask

  task automatic t_reset();
    #1;
    chk("R1", "busy in reset", int'(busy), 0);
    chk("R1", "strobes in reset", int'(dac_s | gain_s | ofs_s | cal_rst), 0);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk); #1;
    chk("R1", "busy after reset", int'(busy), 0);
    chk("R1", "outputs after reset", int'(dac_s | gain_s | ofs_s | cal_rst | midscale), 0);
  endtask

  task automatic t_full_pin();
    int len, gidx, nd, ng, no, ovl;
    @(negedge clk); cal_type = 2'b00; bipolar = 1'b1; cal_pin = 1'b0;
    @(posedge clk);
    repeat (SYNC - 1) @(posedge clk);
    #1 chk("R2", "reset pulse early", int'(cal_rst), 0);
    @(posedge clk); #1;
    chk("R2", "reset pulse", int'(cal_rst), 1);
    @(posedge clk); #1;
    chk("R12", "reset pulse width", int'(cal_rst), 0);
    @(negedge clk); cal_pin = 1'b1;
    @(posedge clk);
    repeat (SYNC - 1) @(posedge clk);
    #1 chk("R3", "busy before pin start lands", int'(busy), 0);
    @(posedge clk); #1;
    chk("R3", "busy after pin start", int'(busy), 1);
    chk("R4", "dac strobe at start", int'(dac_s), 1);
    track(len, gidx, nd, ng, no, ovl);
    chk("R4", "first phase length", len, DAC + GAIN);
    chk("R4", "gain strobe offset", gidx, DAC);
    chk("R4", "dac strobes", nd, 1);
    chk("R4", "gain strobes", ng, 1);
    chk("R12", "overlapping strobes", ovl, 0);
    idle_watch("R4", 5);
    convst_go();
    chk("R5", "busy on convst", int'(busy), 1);
    chk("R5", "ofs strobe", int'(ofs_s), 1);
    chk("R11", "midscale target bipolar", int'(midscale), 1);
    @(negedge clk); convst = 1'b0;
    @(posedge clk); #1;
    track(len, gidx, nd, ng, no, ovl);
    chk("R5", "offset phase length", len + 1, OFS);
    chk("R11", "target held", int'(midscale), 1);
    convst_pulse_ignored("R9");
  endtask

  task automatic convst_pulse_ignored(string req);
    @(negedge clk); convst = 1'b1;
    repeat (3) @(negedge clk);
    convst = 1'b0;
    idle_watch(req, 6);
  endtask

  task automatic t_gain_ofs_sw();
    int len, gidx, nd, ng, no, ovl;
    sw_go(2'b01, 1'b0);
    chk("R3", "busy on sw start", int'(busy), 1);
    chk("R6", "gain strobe at start", int'(gain_s), 1);
    track(len, gidx, nd, ng, no, ovl);
    chk("R6", "gain phase length", len, GAIN);
    chk("R6", "no dac strobe", nd, 0);
    idle_watch("R6", 4);
    convst_go();
    chk("R6", "offset pending", int'(ofs_s), 1);
    chk("R11", "zero-scale target", int'(midscale), 0);
    @(negedge clk); convst = 1'b0;
    track(len, gidx, nd, ng, no, ovl);
    chk("R5", "offset length in gain+offset", len, OFS);
  endtask

  task automatic t_gain_only();
    int len, gidx, nd, ng, no, ovl;
    sw_go(2'b10, 1'b1);
    chk("R7", "gain strobe", int'(gain_s), 1);
    track(len, gidx, nd, ng, no, ovl);
    chk("R7", "gain only length", len, GAIN);
    chk("R7", "single gain strobe", ng, 1);
    convst_pulse_ignored("R7");
  endtask

  task automatic t_ofs_only();
    int len, gidx, nd, ng, no, ovl;
    sw_go(2'b11, 1'b1);
    chk("R8", "ofs strobe", int'(ofs_s), 1);
    track(len, gidx, nd, ng, no, ovl);
    chk("R8", "offset only length", len, OFS);
    chk("R8", "no gain or dac strobe", nd + ng, 0);
    chk("R8", "single ofs strobe", no, 1);
  endtask

  task automatic t_busy_ignore();
    int len = 1;
    int extra = 0;
    sw_go(2'b10, 1'b0);
    for (int i = 1; i < 100; i++) begin
      @(negedge clk);
      sw_start = (i == 3);
      cal_type = (i == 3) ? 2'b11 : 2'b10;
      convst = (i >= 3 && i < 6);
      @(posedge clk); #1;
      if (dac_s || gain_s || ofs_s) extra++;
      if (!busy) break;
      len++;
    end
    sw_start = 1'b0; convst = 1'b0;
    chk("R10", "length with restart during busy", len, GAIN);
    chk("R9", "strobes from convst or restart while busy", extra, 0);
    idle_watch("R9", 4);
  endtask

  task automatic t_abort();
    int len, gidx, nd, ng, no, ovl;
    sw_go(2'b00, 1'b0);
    repeat (5) @(posedge clk);
    @(negedge clk); cal_pin = 1'b0;
    @(posedge clk);
    repeat (SYNC - 1) @(posedge clk);
    #1 chk("R2", "still busy before abort lands", int'(busy), 1);
    @(posedge clk); #1;
    chk("R2", "abort drops busy", int'(busy), 0);
    chk("R2", "abort reset pulse", int'(cal_rst), 1);
    repeat (2) @(negedge clk);
    cal_pin = 1'b1;
    @(posedge clk);
    repeat (SYNC) @(posedge clk);
    #1;
    chk("R3", "restart after abort", int'(busy), 1);
    track(len, gidx, nd, ng, no, ovl);
    chk("R4", "full length after restart", len, DAC + GAIN);
    convst_go();
    @(negedge clk); convst = 1'b0;
    track(len, gidx, nd, ng, no, ovl);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_full_pin();
    t_gain_ofs_sw();
    t_gain_only();
    t_ofs_only();
    t_busy_ignore();
    t_abort();
    repeat (5) @(posedge clk);
    finish_run();
  end

endmodule